// File: doc/BRIEF.md
# Pipelined AHB-Lite Manager Data Path

This block is the bus-facing engine of a simple AHB-Lite manager. A local command port hands it one read or write at a time. Each command becomes an address phase on the bus, and the next command's address phase overlaps the current data phase. At most one data phase is outstanding, and at most one address is waiting behind it. Write and read data travel on separate one-way buses, so a write can be followed at once by a read with no idle cycle between them.

The data phase has different rules for each direction. Write data is driven from the first data-phase cycle and does not change while the subordinate stalls. Read data is taken only on the cycle that completes the data phase, and whatever appears on the read bus during wait cycles is ignored. For a byte or halfword write, the value is copied across every lane of the bus, so the lanes named by the size and the low address bits always carry it. For a byte or halfword read, the result is taken from those same lanes and zero-extended before it goes back to the command side.

Top module: `ahb_pipe_mgr`

## Requirements
- R1: While reset is held and on the first cycle after it, htrans shows IDLE (2'b00), rsp_valid is low and cmd_ready is high.
- R2: A command accepted on a rising edge (cmd_valid and cmd_ready both high) appears in the next cycle on haddr, hwrite and hsize, with htrans at NONSEQ (2'b10). While no command is pending, htrans is IDLE.
- R3: While an address phase is shown and hready is low, haddr, hwrite, hsize and htrans keep their values, and cmd_ready is low.
- R4: For a write, hwdata carries the write value from the first cycle of the data phase (the cycle after the address phase saw hready high). It stays unchanged on every wait cycle up to and including the cycle where hready is high.
- R5: Lane placement of write data on the 32-bit default bus. For hsize 0 (byte), hwdata is the low byte of cmd_wdata repeated in all four lanes. For hsize 1 (halfword), hwdata is the low halfword repeated in both halves. For hsize 2 (word), hwdata is cmd_wdata unchanged.
- R6: Read data is captured only on the data-phase cycle where hready is high. rsp_valid pulses for exactly one cycle, on the cycle after that edge, and values on hrdata during wait cycles never reach rsp_rdata.
- R7: Sub-word reads return the addressed lanes zero-extended. For a byte read, rsp_rdata is hrdata byte addr[1:0] in bits 7:0. For a halfword read, it is hrdata halfword addr[1] in bits 15:0. All other bits are zero.
- R8: With hready held high and a command offered on every cycle, address phases follow one another on consecutive cycles, whether they are reads or writes, with no IDLE cycle between them.
- R9: hsize never exceeds the bus width. A command whose size is wider than the bus (size 3 on a 32-bit bus) is issued as a full-width word (hsize 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | The address slot can take the offered command this cycle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_size | input | 3 | Transfer size as log2 of the byte count |
| cmd_addr | input | AW | Byte address, aligned to the size |
| cmd_wdata | input | DW | Write value, right-aligned |
| rsp_valid | output | 1 | One-cycle pulse when read data is returned |
| rsp_rdata | output | DW | Returned read value, zero-extended |
| haddr | output | AW | Bus address |
| hwrite | output | 1 | Bus direction of the current address phase |
| hsize | output | 3 | Bus transfer size |
| htrans | output | 2 | Transfer type: IDLE or NONSEQ |
| hwdata | output | DW | Write data bus |
| hready | input | 1 | Transfer completes on this cycle when high |
| hrdata | input | DW | Read data bus |

## Verification
An accepted command reaches the address outputs one cycle after its accepting edge. Its write data appears one cycle after the edge where that address phase sees hready high. Its read result shows on rsp_valid one cycle after the edge where the data phase sees hready high. The bench plays the subordinate: it decides hready for each coming edge and samples every output at the falling edge just before that edge, so each expected value is compared in exactly the cycle the pipeline produces it. Expected read results are pushed into the scoreboard on the completing cycle and popped only when rsp_valid arrives one cycle later. Random wait states and junk on hrdata during those waits make sure that neither early sampling nor data lost during a stall can go unnoticed.

// File: rtl/ahb_mgr_pkg.sv
package ahb_mgr_pkg;

  // bus transfer type encodings
  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } htrans_e;

  localparam int SIZE_W = 3;

endpackage

// File: rtl/mgr_addr_stage.sv
// Address-phase slot: holds one command on the bus until hready accepts it.
module mgr_addr_stage #(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int SZ_MAX = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hready,
  input  logic          cmd_valid,
  input  logic          cmd_write,
  input  logic [2:0]    cmd_size,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          cmd_ready,
  output logic          ap_valid,
  output logic [AW-1:0] ap_addr,
  output logic          ap_write,
  output logic [2:0]    ap_size,
  output logic [DW-1:0] ap_wdata
);

  localparam logic [2:0] SZ_TOP = 3'(SZ_MAX);

  logic          valid_q, valid_n;
  logic [AW-1:0] addr_q,  addr_n;
  logic          write_q, write_n;
  logic [2:0]    size_q,  size_n;
  logic [DW-1:0] wdata_q, wdata_n;
  logic          load;
  logic [2:0]    size_fit;

  // slot frees when empty or when the bus takes the current address
  assign cmd_ready = ~valid_q | hready;
  assign load      = cmd_ready & cmd_valid;
  assign size_fit  = (cmd_size > SZ_TOP) ? SZ_TOP : cmd_size;

  always_comb begin
    valid_n = valid_q;
    addr_n  = addr_q;
    write_n = write_q;
    size_n  = size_q;
    wdata_n = wdata_q;
    if (cmd_ready) begin
      valid_n = cmd_valid;
    end
    if (load) begin
      addr_n  = cmd_addr;
      write_n = cmd_write;
      size_n  = size_fit;
      wdata_n = cmd_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      write_q <= 1'b0;
      size_q  <= '0;
      wdata_q <= '0;
    end else begin
      valid_q <= valid_n;
      addr_q  <= addr_n;
      write_q <= write_n;
      size_q  <= size_n;
      wdata_q <= wdata_n;
    end
  end

  assign ap_valid = valid_q;
  assign ap_addr  = addr_q;
  assign ap_write = write_q;
  assign ap_size  = size_q;
  assign ap_wdata = wdata_q;

endmodule

// File: rtl/mgr_lane_spread.sv
// Copies the low 2^size bytes of a value into every lane group of the bus.
module mgr_lane_spread #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] din,
  input  logic [2:0]    size,
  output logic [DW-1:0] dout
);

  localparam int NB = DW / 8;
  localparam int LW = $clog2(NB);

  logic [LW-1:0] mask;

  assign mask = LW'((32'd1 << size) - 32'd1);

  for (genvar b = 0; b < NB; b++) begin : g_lane
    localparam logic [LW-1:0] BI = LW'(b);
    logic [LW-1:0] src;
    assign src              = BI & mask;
    assign dout[8*b +: 8]   = din[{src, 3'b000} +: 8];
  end

endmodule

// File: rtl/mgr_lane_pick.sv
// Pulls the addressed lanes out of a full-width word and zero-extends them.
module mgr_lane_pick #(
  parameter int DW = 32,
  parameter int LW = 2
) (
  input  logic [DW-1:0] din,
  input  logic [2:0]    size,
  input  logic [LW-1:0] lo,
  output logic [DW-1:0] dout
);

  localparam int NB = DW / 8;

  logic [LW-1:0] mask;
  logic [LW-1:0] base;

  assign mask = LW'((32'd1 << size) - 32'd1);
  assign base = lo & ~mask;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    localparam logic [LW-1:0] BI = LW'(b);
    logic [LW-1:0] sel;
    assign sel            = base + BI;
    assign dout[8*b +: 8] = (BI <= mask) ? din[{sel, 3'b000} +: 8] : 8'h00;
  end

endmodule

// File: rtl/mgr_data_stage.sv
// Data-phase slot: drives held write data, captures read data on completion.
module mgr_data_stage #(
  parameter int DW = 32,
  parameter int LW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hready,
  input  logic          ap_valid,
  input  logic          ap_write,
  input  logic [2:0]    ap_size,
  input  logic [LW-1:0] ap_lo,
  input  logic [DW-1:0] ap_wdata,
  input  logic [DW-1:0] hrdata,
  output logic [DW-1:0] hwdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);

  logic          dv_q,  dv_n;
  logic          dw_q,  dw_n;
  logic [2:0]    dsz_q, dsz_n;
  logic [LW-1:0] dlo_q, dlo_n;
  logic [DW-1:0] hwd_q, hwd_n;
  logic          rv_q,  rv_n;
  logic [DW-1:0] rd_q,  rd_n;

  logic [DW-1:0] spread_w;
  logic [DW-1:0] pick_w;
  logic          step;
  logic          rd_done;

  mgr_lane_spread #(.DW(DW)) u_spread (
    .din  (ap_wdata),
    .size (ap_size),
    .dout (spread_w)
  );

  mgr_lane_pick #(.DW(DW), .LW(LW)) u_pick (
    .din  (hrdata),
    .size (dsz_q),
    .lo   (dlo_q),
    .dout (pick_w)
  );

  assign step    = hready & ap_valid;
  assign rd_done = dv_q & ~dw_q & hready;

  always_comb begin
    dv_n  = dv_q;
    dw_n  = dw_q;
    dsz_n = dsz_q;
    dlo_n = dlo_q;
    hwd_n = hwd_q;
    rd_n  = rd_q;
    rv_n  = rd_done;
    if (hready) begin
      dv_n = ap_valid;
    end
    if (step) begin
      dw_n  = ap_write;
      dsz_n = ap_size;
      dlo_n = ap_lo;
    end
    // write data only changes when a new write enters its data phase
    if (step & ap_write) begin
      hwd_n = spread_w;
    end
    if (rd_done) begin
      rd_n = pick_w;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dv_q  <= 1'b0;
      dw_q  <= 1'b0;
      dsz_q <= '0;
      dlo_q <= '0;
      hwd_q <= '0;
      rv_q  <= 1'b0;
      rd_q  <= '0;
    end else begin
      dv_q  <= dv_n;
      dw_q  <= dw_n;
      dsz_q <= dsz_n;
      dlo_q <= dlo_n;
      hwd_q <= hwd_n;
      rv_q  <= rv_n;
      rd_q  <= rd_n;
    end
  end

  assign hwdata    = hwd_q;
  assign rsp_valid = rv_q;
  assign rsp_rdata = rd_q;

endmodule

// File: rtl/ahb_pipe_mgr.sv
module ahb_pipe_mgr
  import ahb_mgr_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_write,
  input  logic [2:0]    cmd_size,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] haddr,
  output logic          hwrite,
  output logic [2:0]    hsize,
  output logic [1:0]    htrans,
  output logic [DW-1:0] hwdata,
  input  logic          hready,
  input  logic [DW-1:0] hrdata
);

  localparam int NB     = DW / 8;
  localparam int LW     = $clog2(NB);
  localparam int SZ_MAX = LW;

  logic          ap_valid;
  logic [AW-1:0] ap_addr;
  logic          ap_write;
  logic [2:0]    ap_size;
  logic [DW-1:0] ap_wdata;

  mgr_addr_stage #(.AW(AW), .DW(DW), .SZ_MAX(SZ_MAX)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .hready    (hready),
    .cmd_valid (cmd_valid),
    .cmd_write (cmd_write),
    .cmd_size  (cmd_size),
    .cmd_addr  (cmd_addr),
    .cmd_wdata (cmd_wdata),
    .cmd_ready (cmd_ready),
    .ap_valid  (ap_valid),
    .ap_addr   (ap_addr),
    .ap_write  (ap_write),
    .ap_size   (ap_size),
    .ap_wdata  (ap_wdata)
  );

  mgr_data_stage #(.DW(DW), .LW(LW)) u_data (
    .clk       (clk),
    .rst_n     (rst_n),
    .hready    (hready),
    .ap_valid  (ap_valid),
    .ap_write  (ap_write),
    .ap_size   (ap_size),
    .ap_lo     (ap_addr[LW-1:0]),
    .ap_wdata  (ap_wdata),
    .hrdata    (hrdata),
    .hwdata    (hwdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  assign haddr  = ap_addr;
  assign hwrite = ap_write;
  assign hsize  = ap_size;
  assign htrans = ap_valid ? TR_NONSEQ : TR_IDLE;

endmodule

// File: rtl/ahb_pipe_mgr_chk.sv
module ahb_pipe_mgr_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hready,
  input logic [1:0]    htrans,
  input logic [AW-1:0] haddr,
  input logic          hwrite,
  input logic [2:0]    hsize,
  input logic [DW-1:0] hwdata,
  input logic          cmd_ready,
  input logic          rsp_valid
);

  localparam logic [2:0] SZ_TOP = 3'($clog2(DW / 8));

  // own view of which data phase is on the bus
  logic in_wr, in_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_wr <= 1'b0;
      in_rd <= 1'b0;
    end else if (hready) begin
      in_wr <= (htrans == 2'b10) &&  hwrite;
      in_rd <= (htrans == 2'b10) && !hwrite;
    end
  end

  // R3
  a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans == 2'b10 && !hready) |=>
      (htrans == 2'b10 && $stable(haddr) && $stable(hwrite) && $stable(hsize)));

  // R3
  a_r3_stall_blocks_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans == 2'b10 && !hready) |-> !cmd_ready);

  // R4
  a_r4_wdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wr && !hready) |=> $stable(hwdata));

  // R6
  a_r6_rsp_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(in_rd && hready));

  // R9
  a_r9_size_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans == 2'b10) |-> (hsize <= SZ_TOP));

endmodule

bind ahb_pipe_mgr ahb_pipe_mgr_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hready    (hready),
  .htrans    (htrans),
  .haddr     (haddr),
  .hwrite    (hwrite),
  .hsize     (hsize),
  .hwdata    (hwdata),
  .cmd_ready (cmd_ready),
  .rsp_valid (rsp_valid)
);

// File: tb/test_ahb_pipe_mgr.sv
module test_ahb_pipe_mgr;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk;
  logic          rst_n;
  logic          cmd_valid;
  logic          cmd_ready;
  logic          cmd_write;
  logic [2:0]    cmd_size;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_wdata;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] haddr;
  logic          hwrite;
  logic [2:0]    hsize;
  logic [1:0]    htrans;
  logic [DW-1:0] hwdata;
  logic          hready;
  logic [DW-1:0] hrdata;

  ahb_pipe_mgr #(.AW(AW), .DW(DW)) i_ahb_pipe_mgr (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_write (cmd_write),
    .cmd_size  (cmd_size),
    .cmd_addr  (cmd_addr),
    .cmd_wdata (cmd_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .haddr     (haddr),
    .hwrite    (hwrite),
    .hsize     (hsize),
    .htrans    (htrans),
    .hwdata    (hwdata),
    .hready    (hready),
    .hrdata    (hrdata)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  typedef struct {
    logic        w;
    logic [2:0]  sz;
    logic [31:0] a;
    logic [31:0] d;
  } cmd_t;

  cmd_t        cq[$];
  logic [31:0] rq[$];
  logic [31:0] mem [16];

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  int       stall_mode = 0;
  logic [7:0] lfsr = 8'h5A;
  int       cyc = 0;
  bit       stream_on = 0;
  bit       stream_prev = 0;
  int       last_acc = 0;

  // subordinate-side state
  bit          dp_v = 0;
  logic        dp_w;
  logic [31:0] dp_a;
  logic [2:0]  dp_sz;
  logic [31:0] dp_d;
  logic [31:0] dp_first;
  int          dp_cnt;
  bit          held_v = 0;
  logic [31:0] held_a;
  logic        held_w;
  logic [2:0]  held_s;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] eff_size(input logic [2:0] s);
    return (s > 3'd2) ? 3'd2 : s;
  endfunction

  function automatic logic [31:0] spread_exp(input logic [31:0] d, input logic [2:0] s);
    case (s)
      3'd0:    return {4{d[7:0]}};
      3'd1:    return {2{d[15:0]}};
      default: return d;
    endcase
  endfunction

  function automatic logic [31:0] read_exp(input logic [31:0] word, input logic [31:0] a, input logic [2:0] s);
    logic [31:0] sh;
    sh = word >> (8 * a[1:0]);
    case (s)
      3'd0:    return {24'h0, sh[7:0]};
      3'd1:    return {16'h0, sh[15:0]};
      default: return word;
    endcase
  endfunction

  // subordinate model and monitor, sampling just before each rising edge
  always @(negedge clk) begin
    if (rst_n) begin
      logic        hr;
      logic [31:0] hrd;
      logic [31:0] e;
      cmd_t        c;
      cyc++;
      if (stall_mode == 0) begin
        hr = 1'b1;
      end else begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        hr   = lfsr[0];
      end
      hrd = 32'hBAD0_0000 ^ 32'(cyc);

      // R3: stalled address phase keeps its values and blocks new commands
      if (htrans == 2'b10 && !hready) begin
        chk(cmd_ready == 1'b0, "R3 cmd_ready low during stall", 32'(cmd_ready), 32'h0);
        if (held_v)
          chk(haddr == held_a && hwrite == held_w && hsize == held_s,
              "R3 address held during stall", haddr, held_a);
      end

      // data phase
      if (dp_v) begin
        if (dp_w) begin
          if (dp_cnt == 0) dp_first = hwdata;
          else if (hwdata !== dp_first)
            chk(1'b0, "R4 write data changed in wait", hwdata, dp_first);
          if (hr) begin
            e = spread_exp(dp_d, dp_sz);
            chk(hwdata === dp_first, "R4 write data held to completion", hwdata, dp_first);
            chk(hwdata === e, "R5 write lane placement", hwdata, e);
            case (dp_sz)
              3'd0:    mem[dp_a[5:2]][8*dp_a[1:0] +: 8] = hwdata[8*dp_a[1:0] +: 8];
              3'd1:    mem[dp_a[5:2]][16*dp_a[1] +: 16] = hwdata[16*dp_a[1] +: 16];
              default: mem[dp_a[5:2]] = hwdata;
            endcase
          end
        end else if (hr) begin
          hrd = mem[dp_a[5:2]];
          rq.push_back(read_exp(hrd, dp_a, dp_sz));
        end
        if (hr) dp_v = 0;
        else    dp_cnt++;
      end

      // address phase taken at the coming edge
      if (htrans == 2'b10 && hr) begin
        if (cq.size() == 0) begin
          chk(1'b0, "R2 address phase without command", haddr, 32'h0);
        end else begin
          c = cq.pop_front();
          chk(haddr == c.a && hwrite == c.w, "R2 address phase fields", haddr, c.a);
          chk(hsize == eff_size(c.sz), "R9 hsize within bus width", 32'(hsize), 32'(eff_size(c.sz)));
          dp_v   = 1;
          dp_w   = c.w;
          dp_a   = c.a;
          dp_sz  = eff_size(c.sz);
          dp_d   = c.d;
          dp_cnt = 0;
        end
        if (stream_on) begin
          if (stream_prev)
            chk(cyc - last_acc == 1, "R8 back-to-back address phases", 32'(cyc - last_acc), 32'd1);
          stream_prev = 1;
          last_acc    = cyc;
        end
      end
      held_v = (htrans == 2'b10) && !hr;
      held_a = haddr;
      held_w = hwrite;
      held_s = hsize;

      // response monitor
      if (rsp_valid) begin
        if (rq.size() == 0) begin
          chk(1'b0, "R6 response without completed read", rsp_rdata, 32'h0);
        end else begin
          e = rq.pop_front();
          chk(rsp_rdata === e, "R6 R7 returned read value", rsp_rdata, e);
        end
      end

      hready = hr;
      hrdata = hrd;
    end
  end

  task automatic send(input logic w, input logic [2:0] sz, input logic [31:0] a, input logic [31:0] d);
    cmd_t c;
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_write = w;
    cmd_size  = sz;
    cmd_addr  = a;
    cmd_wdata = d;
    #(CLK_PERIOD / 4);
    while (!cmd_ready) begin
      @(negedge clk);
      #(CLK_PERIOD / 4);
    end
    c.w = w; c.sz = sz; c.a = a; c.d = d;
    cq.push_back(c);
    @(posedge clk);
  endtask

  task automatic stop_cmd();
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  initial begin
    rst_n     = 1'b0;
    cmd_valid = 1'b0;
    cmd_write = 1'b0;
    cmd_size  = 3'd0;
    cmd_addr  = '0;
    cmd_wdata = '0;
    hready    = 1'b1;
    hrdata    = '0;
    for (int i = 0; i < 16; i++) mem[i] = 32'h0102_0304 * (i + 1) ^ 32'h5A00_00A5;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(htrans == 2'b00, "R1 htrans idle after reset", 32'(htrans), 32'h0);
    chk(rsp_valid == 1'b0, "R1 no response after reset", 32'(rsp_valid), 32'h0);
    chk(cmd_ready == 1'b1, "R1 ready after reset", 32'(cmd_ready), 32'h1);

    // zero-wait stream, mixed sizes and directions (R2 R5 R7 R8 R9)
    stream_prev = 0;
    stream_on   = 1;
    send(1'b1, 3'd2, 32'h10, 32'hCAFE_F00D);
    send(1'b0, 3'd2, 32'h10, 32'h0);
    send(1'b1, 3'd0, 32'h21, 32'h0000_00A5);
    send(1'b0, 3'd0, 32'h21, 32'h0);
    send(1'b0, 3'd0, 32'h23, 32'h0);
    send(1'b1, 3'd1, 32'h32, 32'h1234_BEEF);
    send(1'b0, 3'd1, 32'h32, 32'h0);
    send(1'b0, 3'd1, 32'h30, 32'h0);
    send(1'b0, 3'd2, 32'h30, 32'h0);
    send(1'b1, 3'd3, 32'h04, 32'h8765_4321);
    send(1'b0, 3'd2, 32'h04, 32'h0);
    stop_cmd();
    #1 stream_on = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    #1;
    chk(htrans == 2'b00, "R2 idle with no command", 32'(htrans), 32'h0);

    // random wait states with mixed traffic (R3 R4 R6)
    stall_mode = 1;
    for (int i = 0; i < 48; i++) begin
      logic [2:0]  sz;
      logic [31:0] a;
      logic [3:0]  wi;
      sz = 3'(i % 3);
      wi = 4'((i * 5) % 16);
      case (sz)
        3'd0:    a = {26'h0, wi, 2'(i % 4)};
        3'd1:    a = {26'h0, wi, 1'(i % 2), 1'b0};
        default: a = {26'h0, wi, 2'b00};
      endcase
      send(1'(((i / 2) % 2) == 0), sz, a, 32'h1357_9BDF * (i + 3));
    end
    stop_cmd();
    repeat (40) @(posedge clk);
    stall_mode = 0;
    repeat (4) @(posedge clk);
    chk(cq.size() == 0 && rq.size() == 0, "R6 every read answered once",
        32'(cq.size() + rq.size()), 32'h0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule